// File: doc/BRIEF.md
# APB UART with Edge-Triggered, Sticky Interrupts

This block is a serial port that sits on an APB slave interface. Software writes a byte into a one-byte transmit holding register. The serializer takes that byte and sends it as an 8N1 frame on `txd`: a low start bit, eight data bits with the least significant bit first, and a high stop bit. A receiver watches `rxd`. It times each frame from the falling edge of the start bit, samples every bit at its midpoint, and places the finished byte in a one-byte receive holding register. Both holding registers are a single byte deep. A buffer that is not full is therefore empty. The bit time, counted in clock cycles, is set by a programmable divisor.

The interrupt flags are edge-driven and sticky. The transmit flag is raised at the moment the holding register hands its byte to the serializer, which is the full-to-empty transition, and only if the transmit interrupt is enabled. A transmit buffer that is merely sitting empty never raises it. The receive flag is raised when a byte lands in an empty receive buffer. Both flags are kept in their own status register, apart from the buffer-full bits. They stay set until software writes a one to the matching bit. The block drives one output per flag and a combined output. Transfers complete with no wait states.

Top module: `uart_apb_edgeirq`

## Requirements
- R1: After reset, the state, control and interrupt status registers read 0, the divisor reads 16, `txd` is high and all three interrupt outputs are low.
- R2: When control bit 0 (transmit enable) is set, a byte in the transmit buffer goes out as start(0), data bits 0..7, stop(1). Each bit lasts exactly divisor clock cycles. `txd` is high when idle.
- R3: Interrupt register bit 0 (transmit flag) is set only when the transmit buffer goes from full to empty while control bit 2 is set. With the buffer empty and no prior full state, enabling the interrupt never sets the flag. With control bit 2 clear, a transfer does not set the flag.
- R4: Interrupt register bit 1 (receive flag) is set when a received byte fills the empty receive buffer while control bit 3 is set. With control bit 3 clear, the flag stays 0.
- R5: The state register at offset 0x04 shows transmit buffer full in bit 0 and receive buffer full in bit 1. The pending flags are read at offset 0x0C and are independent of these bits.
- R6: Pending flags stay set until a one is written to their bit at 0x0C. Writing a zero leaves a flag unchanged. When a clear and a set event fall in the same cycle, the flag ends up set.
- R7: A write to the data register (0x00) while the transmit buffer is full is ignored. The byte already held is the one transmitted.
- R8: A read of the data register returns the received byte and clears state bit 1.
- R9: A byte that completes while the receive buffer is full sets state bit 3 (overrun) and leaves the held byte unchanged. Bit 3 stays set until a one is written to state bit 3.
- R10: The receiver samples each bit at its midpoint, timed from the start bit's falling edge. A start bit that is no longer low at its midpoint is rejected, and no byte is stored. A frame whose stop bit is low is discarded.
- R11: `irq_tx` follows the transmit flag, `irq_rx` follows the receive flag, and `irq_any` is their OR.
- R12: With control bit 1 (receive enable) clear, incoming frames are not received.
- R13: Control (0x08, bits 3:0) and divisor (0x10) read back as written. The divisor must be at least 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high (no wait states) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_tx | output | 1 | Transmit flag pending |
| irq_rx | output | 1 | Receive flag pending |
| irq_any | output | 1 | Either flag pending |

## Verification
The hardest case to reach from the ports is a flag clear that lands in the very cycle the transmit flag is being set. In that cycle the second byte of a back-to-back pair moves from the holding register into the serializer. The stimulus sends an all-ones byte followed by a second byte, then sweeps the cycle of a single clear write across a window that straddles the hand-over. The bench records the cycle in which `txd` falls for the second start bit, which is the hand-over cycle. A clear at or before that cycle must leave the flag set, and a later clear must leave it clear. A full sweep of all 256 byte values through a loopback from `txd` to `rxd` covers the serializer, the receiver and both flags together.

// File: rtl/uart_edge_pkg.sv
`timescale 1ns/1ps
package uart_edge_pkg;

    // Word offsets (byte address bits above [1:0])
    localparam int unsigned OFS_DATA = 0;
    localparam int unsigned OFS_STAT = 1;
    localparam int unsigned OFS_CTRL = 2;
    localparam int unsigned OFS_IRQ  = 3;
    localparam int unsigned OFS_DIV  = 4;

    // Control register bits
    localparam int unsigned CTL_TXEN = 0;
    localparam int unsigned CTL_RXEN = 1;
    localparam int unsigned CTL_TXIE = 2;
    localparam int unsigned CTL_RXIE = 3;

    // State register bits
    localparam int unsigned ST_TXFULL = 0;
    localparam int unsigned ST_RXFULL = 1;
    localparam int unsigned ST_OVR    = 3;

    // Interrupt status / clear bits
    localparam int unsigned IRQ_TX = 0;
    localparam int unsigned IRQ_RX = 1;

    localparam int unsigned FRAME_BITS = 10;

    typedef enum logic [1:0] {
        RXP_IDLE,
        RXP_START,
        RXP_BITS,
        RXP_STOP
    } rx_phase_e;

endpackage

// File: rtl/uart_edge_txser.sv
`timescale 1ns/1ps
module uart_edge_txser #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             avail,
    input  logic [7:0]       byte_in,
    output logic             load,
    output logic             txd
);
    import uart_edge_pkg::*;

    typedef struct packed {
        logic             busy;
        logic [9:0]       shreg;
        logic [3:0]       nleft;
        logic [DIV_W-1:0] cnt;
    } tx_st_t;

    localparam tx_st_t TX_RST = '{busy: 1'b0, shreg: '1, nleft: '0, cnt: '0};

    tx_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        load = 1'b0;
        if (!s_q.busy) begin
            if (en && avail) begin
                load       = 1'b1;
                s_d.busy   = 1'b1;
                s_d.shreg  = {1'b1, byte_in, 1'b0};
                s_d.nleft  = 4'(FRAME_BITS);
                s_d.cnt    = div - DIV_W'(1);
            end
        end else if (s_q.cnt == '0) begin
            if (s_q.nleft == 4'd1) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.shreg = {1'b1, s_q.shreg[9:1]};
                s_d.nleft = s_q.nleft - 4'd1;
                s_d.cnt   = div - DIV_W'(1);
            end
        end else begin
            s_d.cnt = s_q.cnt - DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= TX_RST;
        else        s_q <= s_d;
    end

    assign txd = s_q.busy ? s_q.shreg[0] : 1'b1;

    AST_TX_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (s_q.busy && s_q.nleft == 4'd1) |-> txd); // R2
    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n) load |=> !txd); // R2

endmodule

// File: rtl/uart_edge_rxdes.sv
`timescale 1ns/1ps
module uart_edge_rxdes #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             rxd,
    output logic             done,
    output logic [7:0]       byte_out
);
    import uart_edge_pkg::*;

    typedef struct packed {
        logic [2:0]       sync;
        rx_phase_e        phase;
        logic [DIV_W-1:0] cnt;
        logic [2:0]       idx;
        logic [7:0]       shreg;
        logic             done;
        logic [7:0]       data;
    } rx_st_t;

    localparam rx_st_t RX_RST = '{sync: '1, phase: RXP_IDLE, cnt: '0, idx: '0,
                                  shreg: '0, done: 1'b0, data: '0};

    rx_st_t s_d, s_q;
    logic   rx_s;
    logic   fall;

    assign rx_s = s_q.sync[1];
    assign fall = s_q.sync[2] && !s_q.sync[1];

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[1:0], rxd};
        s_d.done = 1'b0;
        if (!en) begin
            s_d.phase = RXP_IDLE;
        end else begin
            unique case (s_q.phase)
                RXP_IDLE: begin
                    if (fall) begin
                        s_d.phase = RXP_START;
                        s_d.cnt   = (div >> 1) - DIV_W'(1);
                    end
                end
                RXP_START: begin
                    if (s_q.cnt == '0) begin
                        if (!rx_s) begin
                            s_d.phase = RXP_BITS;
                            s_d.cnt   = div - DIV_W'(1);
                            s_d.idx   = '0;
                        end else begin
                            s_d.phase = RXP_IDLE;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt - DIV_W'(1);
                    end
                end
                RXP_BITS: begin
                    if (s_q.cnt == '0) begin
                        s_d.shreg = {rx_s, s_q.shreg[7:1]};
                        s_d.cnt   = div - DIV_W'(1);
                        if (s_q.idx == 3'd7) s_d.phase = RXP_STOP;
                        else                 s_d.idx   = s_q.idx + 3'd1;
                    end else begin
                        s_d.cnt = s_q.cnt - DIV_W'(1);
                    end
                end
                RXP_STOP: begin
                    if (s_q.cnt == '0) begin
                        s_d.phase = RXP_IDLE;
                        if (rx_s) begin
                            s_d.done = 1'b1;
                            s_d.data = s_q.shreg;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt - DIV_W'(1);
                    end
                end
                default: s_d.phase = RXP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RX_RST;
        else        s_q <= s_d;
    end

    assign done     = s_q.done;
    assign byte_out = s_q.data;

    AST_RX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n) (s_q.phase == RXP_BITS && $past(s_q.phase) == RXP_START) |-> !$past(rx_s)); // R10
    AST_RX_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n) done |-> ($past(rx_s) && $past(s_q.phase) == RXP_STOP)); // R10

endmodule

// File: rtl/uart_edge_regs.sv
`timescale 1ns/1ps
module uart_edge_regs #(
    parameter int          ADDR_W  = 12,
    parameter int          DIV_W   = 16,
    parameter int unsigned DIV_RST = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic              tx_load,
    input  logic              rx_done,
    input  logic [7:0]        rx_byte,
    output logic              tx_en,
    output logic              rx_en,
    output logic [DIV_W-1:0]  div,
    output logic              tx_avail,
    output logic [7:0]        tx_byte,
    output logic              irq_tx,
    output logic              irq_rx
);
    import uart_edge_pkg::*;

    localparam int WORD_W = ADDR_W - 2;

    typedef struct packed {
        logic [3:0]       ctrl;
        logic [DIV_W-1:0] div;
        logic             tx_full;
        logic [7:0]       tx_buf;
        logic             rx_full;
        logic [7:0]       rx_buf;
        logic             ovr;
        logic             flag_tx;
        logic             flag_rx;
    } reg_st_t;

    localparam reg_st_t REG_RST = '{ctrl: '0, div: DIV_W'(DIV_RST), tx_full: 1'b0,
                                    tx_buf: '0, rx_full: 1'b0, rx_buf: '0, ovr: 1'b0,
                                    flag_tx: 1'b0, flag_rx: 1'b0};

    reg_st_t r_d, r_q;

    logic [WORD_W-1:0] word;
    logic acc, wr, rd;
    logic sel_data, sel_stat, sel_ctrl, sel_irq, sel_div;
    logic wr_data, rd_data, wr_stat, wr_irq;
    logic rx_busy, rx_store, tx_set, rx_set, ovr_set;
    logic unused_bits;

    assign word     = paddr[ADDR_W-1:2];
    assign acc      = psel && penable;
    assign wr       = acc && pwrite;
    assign rd       = acc && !pwrite;
    assign sel_data = (word == WORD_W'(OFS_DATA));
    assign sel_stat = (word == WORD_W'(OFS_STAT));
    assign sel_ctrl = (word == WORD_W'(OFS_CTRL));
    assign sel_irq  = (word == WORD_W'(OFS_IRQ));
    assign sel_div  = (word == WORD_W'(OFS_DIV));
    assign wr_data  = wr && sel_data;
    assign rd_data  = rd && sel_data;
    assign wr_stat  = wr && sel_stat;
    assign wr_irq   = wr && sel_irq;
    assign unused_bits = ^{paddr[1:0], pwdata};

    always_comb begin
        r_d = r_q;

        // transmit holding register
        if (tx_load) r_d.tx_full = 1'b0;
        if (wr_data && !r_q.tx_full) begin
            r_d.tx_buf  = pwdata[7:0];
            r_d.tx_full = 1'b1;
        end

        // receive holding register (a read frees the slot first)
        if (rd_data) r_d.rx_full = 1'b0;
        rx_busy  = r_q.rx_full && !rd_data;
        rx_store = rx_done && !rx_busy;
        ovr_set  = rx_done && rx_busy;
        if (rx_store) begin
            r_d.rx_buf  = rx_byte;
            r_d.rx_full = 1'b1;
        end

        // configuration
        if (wr && sel_ctrl) r_d.ctrl = pwdata[3:0];
        if (wr && sel_div)  r_d.div  = pwdata[DIV_W-1:0];

        // sticky flags, a set event beats a clear in the same cycle
        tx_set = tx_load  && r_q.ctrl[CTL_TXIE];
        rx_set = rx_store && r_q.ctrl[CTL_RXIE];
        r_d.flag_tx = (r_q.flag_tx && !(wr_irq && pwdata[IRQ_TX])) || tx_set;
        r_d.flag_rx = (r_q.flag_rx && !(wr_irq && pwdata[IRQ_RX])) || rx_set;
        r_d.ovr     = (r_q.ovr && !(wr_stat && pwdata[ST_OVR])) || ovr_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REG_RST;
        else        r_q <= r_d;
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            if (sel_data) prdata[7:0] = r_q.rx_buf;
            if (sel_stat) begin
                prdata[ST_TXFULL] = r_q.tx_full;
                prdata[ST_RXFULL] = r_q.rx_full;
                prdata[ST_OVR]    = r_q.ovr;
            end
            if (sel_ctrl) prdata[3:0] = r_q.ctrl;
            if (sel_irq) begin
                prdata[IRQ_TX] = r_q.flag_tx;
                prdata[IRQ_RX] = r_q.flag_rx;
            end
            if (sel_div) prdata[DIV_W-1:0] = r_q.div;
        end
    end

    assign tx_en    = r_q.ctrl[CTL_TXEN];
    assign rx_en    = r_q.ctrl[CTL_RXEN];
    assign div      = r_q.div;
    assign tx_avail = r_q.tx_full;
    assign tx_byte  = r_q.tx_buf;
    assign irq_tx   = r_q.flag_tx;
    assign irq_rx   = r_q.flag_rx;

    AST_TXFLAG_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n) $rose(r_q.flag_tx) |-> ($past(r_q.tx_full) && !r_q.tx_full && $past(r_q.ctrl[CTL_TXIE]))); // R3
    AST_RXFLAG_ON_FILL: assert property (@(posedge clk) disable iff (!rst_n) $rose(r_q.flag_rx) |-> (r_q.rx_full && (!$past(r_q.rx_full) || $past(rd_data)))); // R4
    AST_TXFLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (r_q.flag_tx && !(wr_irq && pwdata[IRQ_TX])) |=> r_q.flag_tx); // R6
    AST_RXFLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (r_q.flag_rx && !(wr_irq && pwdata[IRQ_RX])) |=> r_q.flag_rx); // R6
    AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (wr_data && r_q.tx_full) |=> $stable(r_q.tx_buf)); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (r_q.ovr && !(wr_stat && pwdata[ST_OVR])) |=> r_q.ovr); // R9

endmodule

// File: rtl/uart_apb_edgeirq.sv
`timescale 1ns/1ps
module uart_apb_edgeirq #(
    parameter int          ADDR_W  = 12,
    parameter int          DIV_W   = 16,
    parameter int unsigned DIV_RST = 16
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    input  logic              rxd,
    output logic              txd,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_any
);

    logic             tx_en, rx_en, tx_avail, tx_load, rx_done;
    logic [DIV_W-1:0] div;
    logic [7:0]       tx_byte, rx_byte;

    uart_edge_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) regs_i (
        .clk      (pclk),
        .rst_n    (presetn),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .prdata   (prdata),
        .tx_load  (tx_load),
        .rx_done  (rx_done),
        .rx_byte  (rx_byte),
        .tx_en    (tx_en),
        .rx_en    (rx_en),
        .div      (div),
        .tx_avail (tx_avail),
        .tx_byte  (tx_byte),
        .irq_tx   (irq_tx),
        .irq_rx   (irq_rx)
    );

    uart_edge_txser #(.DIV_W(DIV_W)) tx_i (
        .clk     (pclk),
        .rst_n   (presetn),
        .en      (tx_en),
        .div     (div),
        .avail   (tx_avail),
        .byte_in (tx_byte),
        .load    (tx_load),
        .txd     (txd)
    );

    uart_edge_rxdes #(.DIV_W(DIV_W)) rx_i (
        .clk      (pclk),
        .rst_n    (presetn),
        .en       (rx_en),
        .div      (div),
        .rxd      (rxd),
        .done     (rx_done),
        .byte_out (rx_byte)
    );

    assign pready  = 1'b1;
    assign irq_any = irq_tx || irq_rx;

    AST_TX_LOAD_NEEDS_EN: assert property (@(posedge pclk) disable iff (!presetn) tx_load |-> (tx_en && tx_avail)); // R2
    AST_RX_GATED_OFF: assert property (@(posedge pclk) disable iff (!presetn) (!rx_en && !$past(rx_en)) |-> !rx_done); // R12

endmodule

// File: tb/uart_apb_edgeirq_tb_top.sv
`timescale 1ns/1ps
module uart_apb_edgeirq_tb_top;

    localparam logic [11:0] A_DATA = 12'h000;
    localparam logic [11:0] A_STAT = 12'h004;
    localparam logic [11:0] A_CTRL = 12'h008;
    localparam logic [11:0] A_IRQ  = 12'h00C;
    localparam logic [11:0] A_DIV  = 12'h010;

    logic        clk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, txd, irq_tx, irq_rx, irq_any;
    logic        rxd_drv = 1'b1;
    logic        loop = 1'b0;
    logic        rxd_w;

    int     n_cmp = 0;
    int     n_bad = 0;
    longint cyc = 0;
    logic   armed = 1'b0;
    logic   fall_seen = 1'b0;
    longint fall_cyc = 0;
    logic   done = 1'b0;

    assign rxd_w = loop ? txd : rxd_drv;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!armed) fall_seen <= 1'b0;
        else if (!fall_seen && !txd) begin
            fall_seen <= 1'b1;
            fall_cyc  <= cyc;
        end
    end

    uart_apb_edgeirq dut_i (
        .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .rxd(rxd_w), .txd(txd), .irq_tx(irq_tx),
        .irq_rx(irq_rx), .irq_any(irq_any)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d, output longint c);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(posedge clk);
        #1;
        c = cyc;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        longint c;
        apb_wr(a, d, c);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        d = prdata;
        @(posedge clk);
        #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic cap_frame(input int dv, output logic [7:0] b, output logic stop_ok);
        @(negedge clk);
        while (txd) @(negedge clk);
        repeat (dv / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (dv) @(negedge clk);
            b[i] = txd;
        end
        repeat (dv) @(negedge clk);
        stop_ok = txd;
    endtask

    task automatic send_rx(input logic [7:0] b, input int dv);
        logic [9:0] f;
        f = {1'b1, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            rxd_drv = f[i];
            repeat (dv - 1) @(negedge clk);
        end
    endtask

    task automatic loop_byte(input logic [7:0] b, input int dv);
        logic [7:0]  got;
        logic        stop_ok;
        logic [31:0] v;
        wr(A_IRQ, 32'h3);
        fork
            wr(A_DATA, {24'h0, b});
            cap_frame(dv, got, stop_ok);
        join
        chk("R2", "frame data", {24'h0, got}, {24'h0, b});
        chk("R2", "stop bit", {31'h0, stop_ok}, 32'h1);
        repeat (dv + 8) @(negedge clk);
        rd(A_STAT, v);
        chk("R5", "state rx full only", v, 32'h2);
        rd(A_IRQ, v);
        chk("R3", "tx flag after hand-over", {31'h0, v[0]}, 32'h1);
        chk("R4", "rx flag after fill", {31'h0, v[1]}, 32'h1);
        chk("R11", "irq_any", {31'h0, irq_any}, 32'h1);
        rd(A_DATA, v);
        chk("R8", "received byte", v, {24'h0, b});
        rd(A_STAT, v);
        chk("R8", "rx full cleared by read", v, 32'h0);
    endtask

    initial begin : main
        logic [31:0] v;
        logic [7:0]  got;
        logic        stop_ok;
        longint      clr_c;
        repeat (4) @(negedge clk);
        presetn = 1'b1;
        @(negedge clk);

        // R1 reset values
        chk("R1", "txd idle", {31'h0, txd}, 32'h1);
        chk("R1", "irq_any", {31'h0, irq_any}, 32'h0);
        rd(A_STAT, v); chk("R1", "state", v, 32'h0);
        rd(A_IRQ, v);  chk("R1", "irq status", v, 32'h0);
        rd(A_CTRL, v); chk("R1", "control", v, 32'h0);
        rd(A_DIV, v);  chk("R1", "divisor", v, 32'd16);

        // R3: enabling the tx interrupt on an empty buffer sets nothing
        wr(A_DIV, 32'd4);
        wr(A_CTRL, 32'h7);
        rd(A_CTRL, v); chk("R13", "control readback", v, 32'h7);
        rd(A_DIV, v);  chk("R13", "divisor readback", v, 32'd4);
        repeat (30) @(negedge clk);
        rd(A_IRQ, v); chk("R3", "no flag from idle empty buffer", v, 32'h0);
        chk("R11", "irq_tx pin idle", {31'h0, irq_tx}, 32'h0);

        // full byte sweep through loopback
        loop = 1'b1;
        wr(A_CTRL, 32'hF);
        for (int b = 0; b < 256; b++) loop_byte(b[7:0], 4);

        // divisor variants
        for (int k = 0; k < 4; k++) begin
            int dv;
            dv = (k == 0) ? 5 : (k == 1) ? 7 : (k == 2) ? 11 : 16;
            wr(A_DIV, dv);
            loop_byte(8'hA5 ^ dv[7:0], dv);
        end

        // R7: write while full is ignored
        wr(A_DIV, 32'd4);
        wr(A_CTRL, 32'h2);
        wr(A_IRQ, 32'h3);
        wr(A_DATA, 32'h3C);
        wr(A_DATA, 32'hC3);
        rd(A_STAT, v); chk("R7", "tx full held", v, 32'h1);
        fork
            wr(A_CTRL, 32'h3);
            cap_frame(4, got, stop_ok);
        join
        chk("R7", "first byte kept", {24'h0, got}, 32'h3C);
        repeat (16) @(negedge clk);
        rd(A_IRQ, v); chk("R3", "no flags with interrupts disabled", v, 32'h0);
        rd(A_DATA, v); chk("R8", "looped byte", v, 32'h3C);
        repeat (60) @(negedge clk);
        rd(A_STAT, v); chk("R7", "second byte never queued", v, 32'h0);

        // R12: receiver disabled
        loop = 1'b0;
        wr(A_CTRL, 32'h9);
        send_rx(8'h77, 4);
        repeat (8) @(negedge clk);
        rd(A_STAT, v); chk("R12", "no byte with rx off", v, 32'h0);
        rd(A_IRQ, v);  chk("R12", "no flag with rx off", v, 32'h0);

        // R10: short start pulse rejected, then a proper frame
        wr(A_CTRL, 32'hA);
        wr(A_DIV, 32'd8);
        @(negedge clk); rxd_drv = 1'b0;
        repeat (2) @(negedge clk); rxd_drv = 1'b1;
        repeat (100) @(negedge clk);
        rd(A_STAT, v); chk("R10", "glitch rejected", v, 32'h0);
        send_rx(8'h5A, 8);
        repeat (8) @(negedge clk);
        rd(A_STAT, v); chk("R10", "frame after glitch", v, 32'h2);
        rd(A_IRQ, v);  chk("R4", "rx flag only", v, 32'h2);
        chk("R11", "irq_rx pin", {31'h0, irq_rx}, 32'h1);
        chk("R11", "irq_tx pin", {31'h0, irq_tx}, 32'h0);

        // R6: sticky flags, write-one clear
        wr(A_IRQ, 32'h0); rd(A_IRQ, v); chk("R6", "zero write keeps flag", v, 32'h2);
        wr(A_IRQ, 32'h1); rd(A_IRQ, v); chk("R6", "other bit clear keeps flag", v, 32'h2);
        wr(A_IRQ, 32'h2); rd(A_IRQ, v); chk("R6", "one write clears flag", v, 32'h0);
        chk("R11", "irq_any after clear", {31'h0, irq_any}, 32'h0);
        rd(A_DATA, v); chk("R8", "data after flag clear", v, 32'h5A);

        // R9: overrun
        send_rx(8'h11, 8);
        send_rx(8'h22, 8);
        repeat (10) @(negedge clk);
        rd(A_STAT, v); chk("R9", "overrun and full", v, 32'hA);
        rd(A_DATA, v); chk("R9", "first byte kept", v, 32'h11);
        rd(A_STAT, v); chk("R9", "overrun sticky after read", v, 32'h8);
        wr(A_STAT, 32'h0); rd(A_STAT, v); chk("R9", "zero write keeps overrun", v, 32'h8);
        wr(A_STAT, 32'h8); rd(A_STAT, v); chk("R9", "one write clears overrun", v, 32'h0);

        // R6: clear swept across the cycle the flag is set
        wr(A_DIV, 32'd4);
        wr(A_CTRL, 32'h5);
        for (int k = 0; k < 48; k++) begin
            int guard;
            wr(A_IRQ, 32'h3);
            wr(A_DATA, 32'hFF);
            repeat (3) @(negedge clk);
            wr(A_DATA, 32'h00);
            armed = 1'b0;
            @(negedge clk);
            @(negedge clk);
            #1 armed = 1'b1;
            wr(A_IRQ, 32'h1);
            repeat (k) @(negedge clk);
            apb_wr(A_IRQ, 32'h1, clr_c);
            guard = 0;
            while (!fall_seen && guard < 200) begin
                @(negedge clk);
                guard++;
            end
            repeat (2) @(negedge clk);
            rd(A_IRQ, v);
            chk("R6", "set wins over same-cycle clear", v,
                (fall_seen && clr_c <= fall_cyc) ? 32'h1 : 32'h0);
            armed = 1'b0;
            repeat (50) @(negedge clk);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule